// File: doc/BRIEF.md
# Quadrature Wheel Distance Counter

This block turns the two phase signals of an incremental encoder on a measuring wheel into a signed travel count. It counts both edges of both phases, so one full electrical cycle of the encoder adds four counts. A 1024-line encoder therefore gives 4096 counts per wheel turn. A scheduler downstream uses the count as its distance base, for example to fire an actuator once a product has moved a set distance past a sensor.

Because that scheduler must trust the count, the block also checks that the count is plausible. It sets a sticky fault when both phases change in the same sample. Such a change has no defined direction, so it is not counted. It sets a second sticky fault when the net count change within a fixed window of clock cycles is larger than the wheel could physically produce. The count register wraps modulo 2^32, so differences taken across a wrap remain correct. The direction of the last legal step is reported as well.

Both phase inputs pass through synchronizer flops first, so they may be fully asynchronous to the clock. The reset is synchronous. At the default parameters, one window is 1 ms at 250 MHz and allows up to 100 counts, which is 100 kHz. The worked example (80 mm wheel, 1.40 m/s) produces about 22.8 kHz.

Top module: `wheel_quad_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `position` becomes 0, `dir_up` becomes 1, and `err_illegal` and `err_overspeed` become 0.
- R2: The phase state is the pair {enc_a, enc_b}. Each step along 00→01→11→10→00 adds one to `position`. Each step along the reverse sequence subtracts one. Every edge of both phases counts.
- R3: A phase change that is applied before clock edge k appears in `position` after edge k+2, and not before. This is two synchronizer flops plus the count register.
- R4: `position` is 32 bits wide and wraps modulo 2^32. One down step from 0 gives 0xFFFFFFFF, and one up step from 0xFFFFFFFF gives 0.
- R5: `dir_up` is 1 after a legal up step and 0 after a legal down step. Without a new legal step it keeps its value.
- R6: If both phase bits change in the same sample, `err_illegal` is set and `position` does not change. The new state becomes the reference, so the next legal step is counted from it.
- R7: The clock is divided into consecutive windows of WIN_CYCLES cycles. If the absolute value of the net count change within a window exceeds MAX_STEPS, `err_overspeed` is set. Back-and-forth jitter with a small net change does not set it.
- R8: The phase state held during reset becomes the reference state. Releasing reset with any phase state, including 11, changes neither the count nor either fault.
- R9: `err_illegal` and `err_overspeed` stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| position | output | 32 | Wrapping signed travel count |
| dir_up | output | 1 | Direction of the last legal step, 1 = up |
| err_illegal | output | 1 | Sticky fault: both phases changed at once |
| err_overspeed | output | 1 | Sticky fault: net count per window above the limit |

## Verification
The over-speed fault is the hardest case to reach from the ports. The window counter runs freely from reset and is not visible, so the stimulus cannot line up with a window edge. The bench therefore sets a short window and a low limit. It drives a fast burst of up steps that lasts longer than one window, so that at least one window holds more than the limit wherever the boundary falls.

All slower stimulus is spaced so that no window can reach the limit. A jitter sequence that flips between two adjacent states at the fast rate shows that the net change, not the edge count, is what is judged. The count wrap is reached in one step, by moving down from zero.

// File: rtl/wqc_pkg.sv
`timescale 1ns/1ps
package wqc_pkg;

  // Difference of Gray indices (modulo 4) maps directly onto the move kind
  typedef enum logic [1:0] {
    MOV_NONE = 2'd0,
    MOV_UP   = 2'd1,
    MOV_ILL  = 2'd2,
    MOV_DOWN = 2'd3
  } move_t;

  // {a,b}: 00->0, 01->1, 11->2, 10->3
  function automatic logic [1:0] phase_index(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

endpackage

// File: rtl/wqc_sync.sv
`timescale 1ns/1ps
module wqc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/wqc_step_decode.sv
`timescale 1ns/1ps
module wqc_step_decode
  import wqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab_now,
  output logic       step_up,
  output logic       step_dn,
  output logic       step_bad
);

  logic [1:0] ab_ref;
  move_t      mv;

  // During reset the reference follows the pins, so release never counts
  always_ff @(posedge clk) ab_ref <= ab_now;

  always_comb begin
    mv = move_t'(phase_index(ab_now) - phase_index(ab_ref));
    if (rst) mv = MOV_NONE;
  end

  assign step_up  = (mv == MOV_UP);
  assign step_dn  = (mv == MOV_DOWN);
  assign step_bad = (mv == MOV_ILL);

  AST_BAD_BOTH_BITS: assert property (@(posedge clk) disable iff (rst)
    step_bad |-> (ab_now[1] != ab_ref[1]) && (ab_now[0] != ab_ref[0])) // R6
    else $error("AST_BAD_BOTH_BITS");

endmodule

// File: rtl/wqc_rate_guard.sv
`timescale 1ns/1ps
module wqc_rate_guard #(
  parameter int WIN_CYCLES = 250000,
  parameter int MAX_STEPS  = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic step_up,
  input  logic step_dn,
  output logic overspeed
);

  localparam int WCNT_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam int ACC_W  = $clog2(WIN_CYCLES + 1) + 1;
  localparam logic [WCNT_W-1:0] WIN_LAST = WCNT_W'(WIN_CYCLES - 1);
  localparam logic [ACC_W-1:0]  LIMIT    = ACC_W'(MAX_STEPS);

  logic [WCNT_W-1:0] win_q;
  logic [ACC_W-1:0]  acc_q, acc_nxt, mag;

  always_comb begin
    acc_nxt = acc_q;
    if (step_up)      acc_nxt = acc_q + ACC_W'(1);
    else if (step_dn) acc_nxt = acc_q - ACC_W'(1);
    mag = acc_nxt[ACC_W-1] ? (~acc_nxt + ACC_W'(1)) : acc_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q     <= '0;
      acc_q     <= '0;
      overspeed <= 1'b0;
    end else begin
      if (win_q == WIN_LAST) begin
        win_q <= '0;
        acc_q <= '0;
      end else begin
        win_q <= win_q + WCNT_W'(1);
        acc_q <= acc_nxt;
      end
      if (mag > LIMIT) overspeed <= 1'b1;
    end
  end

  AST_OVS_STICKY: assert property (@(posedge clk) disable iff (rst)
    overspeed |=> overspeed) // R9
    else $error("AST_OVS_STICKY");

endmodule

// File: rtl/wheel_quad_counter.sv
`timescale 1ns/1ps
module wheel_quad_counter #(
  parameter int POS_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int WIN_CYCLES  = 250000,
  parameter int MAX_STEPS   = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic [POS_W-1:0] position,
  output logic             dir_up,
  output logic             err_illegal,
  output logic             err_overspeed
);

  logic [1:0] ab_sync;
  logic       step_up, step_dn, step_bad;
  logic [POS_W-1:0] pos_q;
  logic       dir_q, ill_q;

  wqc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk (clk),
    .d   ({enc_a, enc_b}),
    .q   (ab_sync)
  );

  wqc_step_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .ab_now   (ab_sync),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .step_bad (step_bad)
  );

  wqc_rate_guard #(.WIN_CYCLES(WIN_CYCLES), .MAX_STEPS(MAX_STEPS)) u_rate (
    .clk       (clk),
    .rst       (rst),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .overspeed (err_overspeed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      dir_q <= 1'b1;
      ill_q <= 1'b0;
    end else begin
      if (step_up) begin
        pos_q <= pos_q + POS_W'(1);
        dir_q <= 1'b1;
      end else if (step_dn) begin
        pos_q <= pos_q - POS_W'(1);
        dir_q <= 1'b0;
      end
      if (step_bad) ill_q <= 1'b1;
    end
  end

  assign position    = pos_q;
  assign dir_up      = dir_q;
  assign err_illegal = ill_q;

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (position == $past(position)) || (position == $past(position) + POS_W'(1)) ||
    (position == $past(position) - POS_W'(1))) // R2
    else $error("AST_UNIT_STEP");

  AST_BAD_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    step_bad |=> position == $past(position)) // R6
    else $error("AST_BAD_NO_COUNT");

  AST_ILL_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_illegal |=> err_illegal) // R9
    else $error("AST_ILL_STICKY");

  AST_DIR_DOWN: assert property (@(posedge clk) disable iff (rst)
    step_dn |=> !dir_up) // R5
    else $error("AST_DIR_DOWN");

endmodule

// File: tb/wheel_quad_counter_test.sv
`timescale 1ns/1ps
module wheel_quad_counter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic [31:0] position;
  logic        dir_up, err_illegal, err_overspeed;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  wheel_quad_counter #(.POS_W(32), .SYNC_STAGES(2), .WIN_CYCLES(64), .MAX_STEPS(6)) uut (
    .clk (clk), .rst (rst), .enc_a (enc_a), .enc_b (enc_b),
    .position (position), .dir_up (dir_up),
    .err_illegal (err_illegal), .err_overspeed (err_overspeed)
  );

  // {a,b, expected dir_up, expected position}, 12-cycle spacing
  localparam logic [34:0] VEC [14] = '{
    {2'b01, 1'b1, 32'd1}, {2'b11, 1'b1, 32'd2}, {2'b10, 1'b1, 32'd3},
    {2'b00, 1'b1, 32'd4}, {2'b01, 1'b1, 32'd5}, {2'b00, 1'b0, 32'd4},
    {2'b10, 1'b0, 32'd3}, {2'b11, 1'b0, 32'd2}, {2'b01, 1'b0, 32'd1},
    {2'b11, 1'b1, 32'd2}, {2'b01, 1'b0, 32'd1}, {2'b00, 1'b0, 32'd0},
    {2'b10, 1'b0, 32'hFFFF_FFFF}, {2'b00, 1'b1, 32'd0}
  };

  function automatic logic [1:0] gray_of(input int i);
    case (i % 4)
      0: return 2'b00;
      1: return 2'b01;
      2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] ab, input int hold);
    {enc_a, enc_b} = ab;
    repeat (hold) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int idx;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk("R1 position", position, 32'd0);
    chk("R1 dir_up", {31'd0, dir_up}, 32'd1);
    chk("R1 err_illegal", {31'd0, err_illegal}, 32'd0);
    chk("R1 err_overspeed", {31'd0, err_overspeed}, 32'd0);

    // Table walk: up, down, reversal and wrap
    for (int i = 0; i < 14; i++) begin
      apply(VEC[i][34:33], 12);
      chk((i >= 12) ? "R4 wrap" : "R2 count", position, VEC[i][31:0]);
      chk("R5 dir", {31'd0, dir_up}, {31'd0, VEC[i][32]});
    end
    chk("R6 no false illegal", {31'd0, err_illegal}, 32'd0);

    // R3 latency: state 00 -> 01
    {enc_a, enc_b} = 2'b01;
    repeat (2) @(negedge clk);
    chk("R3 not before edge k+2", position, 32'd0);
    @(negedge clk);
    chk("R3 after edge k+2", position, 32'd1);
    repeat (9) @(negedge clk);

    // R6: 01 -> 10 changes both bits
    apply(2'b10, 12);
    chk("R6 count held", position, 32'd1);
    chk("R6 flag set", {31'd0, err_illegal}, 32'd1);
    apply(2'b00, 12);
    chk("R6 counts from new state", position, 32'd2);
    chk("R9 illegal sticky", {31'd0, err_illegal}, 32'd1);

    // R8: reset with state 11 held
    apply(2'b11, 12);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    chk("R8 position", position, 32'd0);
    chk("R8 err_illegal", {31'd0, err_illegal}, 32'd0);
    chk("R8 err_overspeed", {31'd0, err_overspeed}, 32'd0);
    apply(2'b10, 12);
    chk("R8 first step from 11", position, 32'd1);

    // R7 jitter: fast toggling with net change 0
    for (int i = 0; i < 40; i++) apply((i % 2 == 0) ? 2'b11 : 2'b10, 4);
    repeat (12) @(negedge clk);
    chk("R7 jitter position", position, 32'd1);
    chk("R7 jitter no alarm", {31'd0, err_overspeed}, 32'd0);

    // R7 burst: 20 up steps, 4 cycles apart, from state 10 (index 3)
    idx = 3;
    for (int k = 0; k < 20; k++) begin
      idx = idx + 1;
      apply(gray_of(idx), 4);
    end
    repeat (12) @(negedge clk);
    chk("R7 burst position", position, 32'd21);
    chk("R7 burst alarm", {31'd0, err_overspeed}, 32'd1);
    chk("R5 burst dir", {31'd0, dir_up}, 32'd1);
    repeat (200) @(negedge clk);
    chk("R9 overspeed sticky", {31'd0, err_overspeed}, 32'd1);

    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 position after burst", position, 32'd0);
    chk("R1 overspeed cleared", {31'd0, err_overspeed}, 32'd0);

    finish_run();
  end

endmodule